// File: doc/BRIEF.md
# Virtual Address Region Translator

This block takes a 32-bit virtual address and works out where the page-table entry for it lives in memory. The two top address bits choose one of four regions. Two regions belong to the running process and one is a system region that every process shares. The fourth code is reserved and never translates. The bits below the region field form a 21-bit virtual page number and a 9-bit byte offset within a 512-byte page. The entry address is the base register of the selected region plus four times the page number. A length register for each region limits how many pages that region may use.

The base and length registers of the two process regions are reloaded together through a context-switch port. The system region's registers have their own load port, so a context switch leaves them alone. A request is accepted with a valid/ready handshake. One cycle after the handshake the block presents the entry address, the byte offset, the region code and a fault code. If a register load arrives in the same cycle as a request, that request already sees the new values.

Top module: `vart_xlate`

## Requirements
- R1: The response region code equals virtual address bits 31:30: 0 and 1 are the two process regions and 2 is the system region.
- R2: A request whose bits 31:30 are 3 returns fault code 1 (reserved region) and an entry address of zero.
- R3: For a request without a fault, the entry address is the selected region's base plus the page number (address bits 29:9) shifted left by two.
- R4: The response offset equals virtual address bits 8:0 for every request, faulting or not.
- R5: A request in regions 0 to 2 whose page number is at or above that region's length returns fault code 2 (length) and an entry address of zero. A page number of length minus one does not fault.
- R6: The response valid is high in exactly the cycle after a completed handshake and low in all other cycles.
- R7: A context-switch load replaces the base and length of regions 0 and 1. The system base and length change only on a system load.
- R8: A load presented in the same cycle as an accepted request takes effect for that request.
- R9: During reset, ready and response valid are low. After reset every base and length is zero, so any translation in regions 0 to 2 returns fault code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address |
| ctx_load | input | 1 | Load both process-region registers |
| ctx_base0 | input | 32 | Incoming base for region 0 |
| ctx_len0 | input | 22 | Incoming length in pages for region 0 |
| ctx_base1 | input | 32 | Incoming base for region 1 |
| ctx_len1 | input | 22 | Incoming length in pages for region 1 |
| sys_load | input | 1 | Load the system-region registers |
| sys_base | input | 32 | Incoming system base |
| sys_len | input | 22 | Incoming system length in pages |
| rsp_valid | output | 1 | Response present |
| rsp_pte_addr | output | 32 | Page-table entry address, zero on fault |
| rsp_offset | output | 9 | Byte offset within the page |
| rsp_region | output | 2 | Region code |
| rsp_fault | output | 2 | 0 none, 1 reserved region, 2 length |

## Verification
A register load and a translation request can land in the same cycle. The bench provokes this by raising the context-switch load or the system load at the same edge as an accepted request whose address lies in the region being reloaded. It judges the outcome by comparing the returned entry address and fault code against the incoming base and length values, which differ from the old ones in both the address and the length limit. A context switch whose request targets the system region checks that the shared base is left unchanged.

// File: rtl/vart_pkg.sv
package vart_pkg;
   localparam int VA_W   = 32;
   localparam int RGN_W  = 2;
   localparam int OFF_W  = 9;
   localparam int VPN_W  = VA_W - RGN_W - OFF_W;
   localparam int LEN_W  = VPN_W + 1;

   typedef enum logic [1:0] {
      RGN_PROC0 = 2'd0,
      RGN_PROC1 = 2'd1,
      RGN_SYS   = 2'd2,
      RGN_RSVD  = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_RSVD = 2'd1,
      FLT_LEN  = 2'd2
   } fault_e;
endpackage

// File: rtl/vart_split.sv
module vart_split #(
   parameter int VA_W  = 32,
   parameter int RGN_W = 2,
   parameter int OFF_W = 9,
   localparam int VPN_W = VA_W - RGN_W - OFF_W
) (
   input  logic [VA_W-1:0]  va,
   output logic [RGN_W-1:0] region,
   output logic [VPN_W-1:0] vpn,
   output logic [OFF_W-1:0] offset
);
   if (VPN_W < 1) begin : g_bad_split
      $error("vart_split: no page-number bits left");
   end

   assign region = va[VA_W-1 -: RGN_W];
   assign vpn    = va[OFF_W +: VPN_W];
   assign offset = va[OFF_W-1:0];
endmodule

// File: rtl/vart_regs.sv
module vart_regs #(
   parameter int PA_W  = 32,
   parameter int LEN_W = 22
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ctx_load,
   input  logic [PA_W-1:0]  ctx_base0,
   input  logic [LEN_W-1:0] ctx_len0,
   input  logic [PA_W-1:0]  ctx_base1,
   input  logic [LEN_W-1:0] ctx_len1,
   input  logic             sys_load,
   input  logic [PA_W-1:0]  sys_base,
   input  logic [LEN_W-1:0] sys_len,
   input  logic [1:0]       sel,
   output logic [PA_W-1:0]  eff_base,
   output logic [LEN_W-1:0] eff_len
);
   logic [PA_W-1:0]  base0_q, base1_q, sbase_q;
   logic [LEN_W-1:0] len0_q, len1_q, slen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         base0_q <= '0; len0_q <= '0;
         base1_q <= '0; len1_q <= '0;
         sbase_q <= '0; slen_q <= '0;
      end else begin
         if (ctx_load) begin
            base0_q <= ctx_base0; len0_q <= ctx_len0;
            base1_q <= ctx_base1; len1_q <= ctx_len1;
         end
         if (sys_load) begin
            sbase_q <= sys_base; slen_q <= sys_len;
         end
      end
   end

   // A load in the request cycle bypasses the stored value (R8).
   always_comb begin
      unique case (sel)
         2'd0: begin
            eff_base = ctx_load ? ctx_base0 : base0_q;
            eff_len  = ctx_load ? ctx_len0  : len0_q;
         end
         2'd1: begin
            eff_base = ctx_load ? ctx_base1 : base1_q;
            eff_len  = ctx_load ? ctx_len1  : len1_q;
         end
         2'd2: begin
            eff_base = sys_load ? sys_base : sbase_q;
            eff_len  = sys_load ? sys_len  : slen_q;
         end
         default: begin
            eff_base = '0;
            eff_len  = '0;
         end
      endcase
   end

   a_r7_sys_untouched: assert property (@(posedge clk) disable iff (rst)
      !sys_load |=> ($stable(sbase_q) && $stable(slen_q)));
   a_r7_ctx_taken: assert property (@(posedge clk) disable iff (rst)
      ctx_load |=> (base0_q == $past(ctx_base0) && base1_q == $past(ctx_base1)));
endmodule

// File: rtl/vart_xlate.sv
module vart_xlate #(
   parameter int  PA_W          = 32,
   parameter int  PTE_SHIFT     = 2,
   parameter bit  LEN_CHECK     = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                req_valid,
   output logic                                req_ready,
   input  logic [vart_pkg::VA_W-1:0]           req_va,
   input  logic                                ctx_load,
   input  logic [PA_W-1:0]                     ctx_base0,
   input  logic [vart_pkg::LEN_W-1:0]          ctx_len0,
   input  logic [PA_W-1:0]                     ctx_base1,
   input  logic [vart_pkg::LEN_W-1:0]          ctx_len1,
   input  logic                                sys_load,
   input  logic [PA_W-1:0]                     sys_base,
   input  logic [vart_pkg::LEN_W-1:0]          sys_len,
   output logic                                rsp_valid,
   output logic [PA_W-1:0]                     rsp_pte_addr,
   output logic [vart_pkg::OFF_W-1:0]          rsp_offset,
   output logic [vart_pkg::RGN_W-1:0]          rsp_region,
   output logic [1:0]                          rsp_fault
);
   import vart_pkg::*;

   if (PA_W < VPN_W + PTE_SHIFT) begin : g_bad_pa
      $error("vart_xlate: PA_W too narrow for scaled page number");
   end

   logic [RGN_W-1:0] region;
   logic [VPN_W-1:0] vpn;
   logic [OFF_W-1:0] offset;
   logic [PA_W-1:0]  base;
   logic [LEN_W-1:0] len;
   logic             len_bad;
   logic [1:0]       fault_d;
   logic [PA_W-1:0]  pte_d;
   logic             accept;

   vart_split #(.VA_W(VA_W), .RGN_W(RGN_W), .OFF_W(OFF_W)) u_split (
      .va(req_va), .region(region), .vpn(vpn), .offset(offset));

   vart_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst(rst),
      .ctx_load(ctx_load), .ctx_base0(ctx_base0), .ctx_len0(ctx_len0),
      .ctx_base1(ctx_base1), .ctx_len1(ctx_len1),
      .sys_load(sys_load), .sys_base(sys_base), .sys_len(sys_len),
      .sel(region), .eff_base(base), .eff_len(len));

   if (LEN_CHECK) begin : g_len_chk
      assign len_bad = ({1'b0, vpn} >= len);
   end else begin : g_no_len_chk
      assign len_bad = 1'b0;
   end

   always_comb begin
      if (region == RGN_RSVD) begin
         fault_d = FLT_RSVD;
         pte_d   = '0;
      end else if (len_bad) begin
         fault_d = FLT_LEN;
         pte_d   = '0;
      end else begin
         fault_d = FLT_NONE;
         pte_d   = base + (PA_W'(vpn) << PTE_SHIFT);
      end
   end

   assign accept = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_ready    <= 1'b0;
         rsp_valid    <= 1'b0;
         rsp_pte_addr <= '0;
         rsp_offset   <= '0;
         rsp_region   <= '0;
         rsp_fault    <= '0;
      end else begin
         req_ready <= 1'b1;
         rsp_valid <= accept;
         if (accept) begin
            rsp_pte_addr <= pte_d;
            rsp_offset   <= offset;
            rsp_region   <= region;
            rsp_fault    <= fault_d;
         end
      end
   end

   a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
      accept |=> rsp_valid);
   a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
      !accept |=> !rsp_valid);
   a_r2_reserved_faults: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_region == 2'd3) |-> (rsp_fault == 2'd1 && rsp_pte_addr == '0));
   a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pte_addr == '0));
   a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (rsp_offset == $past(req_va[OFF_W-1:0])));
   a_r1_region_kept: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (rsp_region == $past(req_va[VA_W-1 -: RGN_W])));
endmodule

// File: tb/tb_vart_xlate.sv
module tb_vart_xlate;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [31:0] req_va = '0;
   logic ctx_load = 1'b0, sys_load = 1'b0;
   logic [31:0] ctx_base0 = '0, ctx_base1 = '0, sys_base = '0;
   logic [21:0] ctx_len0 = '0, ctx_len1 = '0, sys_len = '0;
   logic rsp_valid;
   logic [31:0] rsp_pte_addr;
   logic [8:0] rsp_offset;
   logic [1:0] rsp_region, rsp_fault;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [31:0] m_base [3];
   logic [21:0] m_len [3];

   always #5 clk = ~clk;

   vart_xlate dut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive at a falling edge; the response is registered at the next rising edge.
   task automatic xlate(logic [31:0] va, string req);
      logic [1:0]  rg;
      logic [20:0] vpn;
      logic [1:0]  ef;
      logic [31:0] ea;
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0; ctx_load = 1'b0; sys_load = 1'b0;
      rg = va[31:30]; vpn = va[29:9];
      if (rg == 2'd3) begin ef = 2'd1; ea = '0; end
      else if ({1'b0, vpn} >= m_len[rg]) begin ef = 2'd2; ea = '0; end
      else begin ef = 2'd0; ea = m_base[rg] + ({11'b0, vpn} << 2); end
      check({req, " R6 valid"}, {31'b0, rsp_valid}, 32'd1);
      check({req, " R1 region"}, {30'b0, rsp_region}, {30'b0, rg});
      check({req, " R4 offset"}, {23'b0, rsp_offset}, {23'b0, va[8:0]});
      check({req, " fault"}, {30'b0, rsp_fault}, {30'b0, ef});
      check({req, " R3 pte"}, rsp_pte_addr, ea);
   endtask

   task automatic set_ctx(logic [31:0] b0, logic [21:0] l0, logic [31:0] b1, logic [21:0] l1);
      ctx_load = 1'b1; ctx_base0 = b0; ctx_len0 = l0; ctx_base1 = b1; ctx_len1 = l1;
      m_base[0] = b0; m_len[0] = l0; m_base[1] = b1; m_len[1] = l1;
   endtask

   task automatic set_sys(logic [31:0] b, logic [21:0] l);
      sys_load = 1'b1; sys_base = b; sys_len = l;
      m_base[2] = b; m_len[2] = l;
   endtask

   task automatic idle_load();
      @(negedge clk);
      ctx_load = 1'b0; sys_load = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 ready in reset", {31'b0, req_ready}, 32'd0);
      check("R9 valid in reset", {31'b0, rsp_valid}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R9 ready after reset", {31'b0, req_ready}, 32'd1);
      for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_len[i] = '0; end
      xlate(32'h0000_0000, "R9 zero len");
      xlate(32'h8000_0200, "R9 sys zero len");
   endtask

   task automatic t_regions();
      set_ctx(32'h1000_0000, 22'd100, 32'h2000_0000, 22'd4096);
      set_sys(32'h3000_0000, 22'h20_0000);
      idle_load();
      xlate(32'h0000_0A35, "R1 region0");
      xlate(32'h4012_3456, "R1 region1");
      xlate(32'hBFFF_FFFF, "R3 sys top page");
      xlate(32'h8000_01FF, "R4 sys page0");
   endtask

   task automatic t_reserved();
      xlate(32'hC000_0000, "R2 rsvd low");
      xlate(32'hFFFF_FE7B, "R2 rsvd high");
   endtask

   task automatic t_length();
      xlate({2'b00, 21'd99, 9'h011}, "R5 last page");
      xlate({2'b00, 21'd100, 9'h011}, "R5 at length");
      xlate({2'b01, 21'd5000, 9'h000}, "R5 beyond");
   endtask

   task automatic t_idle_valid();
      @(negedge clk);
      check("R6 idle no valid", {31'b0, rsp_valid}, 32'd0);
   endtask

   task automatic t_ctx_switch();
      set_ctx(32'h0A00_0000, 22'd8, 32'h0B00_0000, 22'd8);
      idle_load();
      xlate({2'b00, 21'd7, 9'h1AB}, "R7 new ctx r0");
      xlate({2'b01, 21'd3, 9'h002}, "R7 new ctx r1");
      xlate({2'b10, 21'd42, 9'h0CC}, "R7 sys kept");
   endtask

   task automatic t_same_cycle();
      set_ctx(32'h5500_0000, 22'd2000, 32'h6600_0000, 22'd1);
      xlate({2'b00, 21'd1500, 9'h055}, "R8 ctx bypass r0");
      set_ctx(32'h7700_0000, 22'd50, 32'h8800_0000, 22'd50);
      xlate({2'b10, 21'd42, 9'h001}, "R8 R7 ctx with sys req");
      set_sys(32'h9900_0000, 22'd10);
      xlate({2'b10, 21'd42, 9'h001}, "R8 sys bypass len");
      set_sys(32'h9A00_0000, 22'd100);
      xlate({2'b10, 21'd42, 9'h003}, "R8 sys bypass addr");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_regions();
      t_reserved();
      t_length();
      t_idle_valid();
      t_ctx_switch();
      t_same_cycle();
      t_idle_valid();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule